// File: doc/BRIEF.md
# Word-Packed I2C Data FIFO Pair

This block holds the data path between a 32-bit register bus and a byte-serial I2C engine. Software writes whole 32-bit words into a transmit FIFO and reads whole words out of a receive FIFO. The engine takes bytes from the transmit side and hands bytes to the receive side, one per handshake. Within a word, lane 0 (bits 7:0) is the first byte on the wire and lane 3 is the last. A transfer carries a byte count, so the last word of a transfer may hold only 1 to 3 valid bytes, placed in the low lanes.

A control word sets a trigger level for each FIFO and holds two flush bits that clear themselves. A status word reports free transmit slots, filled receive words and two sticky error flags. Each side raises a one-cycle request pulse when its fill state reaches the programmed trigger level.

Top module: `i2c_word_fifo_pair`

## Requirements
- R1: After reset the status word (address 1) reads 0x080: 8 free TX slots, 0 RX words, both sticky flags clear. The control word (address 0) reads 0, `eng_tx_valid` is low and `eng_rx_ready` is low.
- R2: A bus write to address 2 pushes one word into the TX FIFO. Status bits 7:4 always show 8 minus the number of TX words held.
- R3: A write to address 2 while the TX FIFO holds 8 words is dropped and sets the sticky overflow flag at status bit 8. The stored words are unchanged.
- R4: During a write transfer (`xfer_start` with `xfer_rd`=0 and `xfer_len`=L), `eng_tx_byte` presents the head word's bytes from lane 0 to lane 3. Each `eng_tx_take` while `eng_tx_valid` is high advances one lane.
- R5: Only L bytes are offered. The word holding byte L is popped right after that byte, and its upper lanes are skipped. `eng_tx_valid` then stays low, and any words behind it remain queued.
- R6: During a read transfer (`xfer_rd`=1, length L), accepted bytes fill lanes 0 to 3 of a word. The word enters the RX FIFO after lane 3 or after byte L. Status bits 3:0 show the RX word count, and a bus read of address 3 returns the head word and pops it.
- R7: A read of address 3 with the RX FIFO empty leaves the count at 0 and sets the sticky underflow flag at status bit 9.
- R8: Writing control bit 1 flushes TX and writing bit 0 flushes RX. The bit reads 1 for the one cycle after the write, then 0. That FIFO is then empty, its sticky flag is clear, and the other FIFO is untouched.
- R9: Control bits 7:5 hold T. `tx_req` pulses for one cycle when the number of free TX slots rises to at least T+1.
- R10: Control bits 4:2 hold R. `rx_req` pulses for one cycle when the RX word count rises to at least R+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe (pops RX at address 3) |
| reg_addr | input | 2 | 0 control, 1 status, 2 TX data, 3 RX data |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data (combinational) |
| xfer_start | input | 1 | Loads a new transfer byte count |
| xfer_rd | input | 1 | Transfer direction, 1 = receive |
| xfer_len | input | LEN_W | Transfer byte count |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_tx_valid | output | 1 | A TX byte is offered |
| eng_tx_take | input | 1 | Engine consumes the offered byte |
| eng_rx_byte | input | 8 | Byte from the engine |
| eng_rx_push | input | 1 | Engine delivers a byte |
| eng_rx_ready | output | 1 | Receive side can accept a byte |
| tx_req | output | 1 | TX request pulse |
| rx_req | output | 1 | RX request pulse |

## Verification
A wrong lane index or a wrong remaining-byte count shows up at `eng_tx_byte` on the very next take. It can also show up as a status free count that fails to return to its full value once a transfer ends. A packer that closes its word at the wrong lane shows up as an RX count that differs from the ceiling of L/4, or as a popped word whose valid lanes hold bytes in the wrong order. A flush or sticky flag that misbehaves is visible in the control and status reads one cycle after the write. A broken crossing detector shows as a pulse count other than one when a level is crossed.

// File: rtl/i2c_wfp_pkg.sv
package i2c_wfp_pkg;
  localparam int STAT_W = 4;
  localparam int TRIG_W = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TXD  = 2'd2,
    SEL_RXD  = 2'd3
  } reg_sel_e;

  // byte at a given lane; lane 0 is first on the wire
  function automatic logic [7:0] lane_get(input logic [31:0] w, input logic [1:0] lane);
    int idx;
    idx = int'(lane) * 8;
    return w[idx +: 8];
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    int idx;
    r = w;
    idx = int'(lane) * 8;
    r[idx +: 8] = b;
    return r;
  endfunction

  // a word is closed at lane 3 or at the final byte of a transfer
  function automatic logic word_done(input logic [1:0] lane, input logic is_last);
    return (lane == 2'd3) || is_last;
  endfunction

  function automatic logic [STAT_W-1:0] trig_level(input logic [TRIG_W-1:0] field);
    return {1'b0, field} + STAT_W'(1);
  endfunction
endpackage

// File: rtl/wfp_fifo.sv
module wfp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             push_rej,
  output logic             pop_rej
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign push_rej = push && full;
  assign pop_rej  = pop && empty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> count == CW'(DEPTH)); // R3
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !flush |=> count == '0); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0); // R8
endmodule

// File: rtl/wfp_tx_unpack.sv
module wfp_tx_unpack
  import i2c_wfp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic             clr,
  input  logic [LEN_W-1:0] len,
  input  logic             word_avail,
  input  logic [31:0]      head,
  input  logic             take,
  output logic [7:0]       byte_o,
  output logic             valid_o,
  output logic             pop_o
);
  logic [1:0]       lane;
  logic [LEN_W-1:0] rem;
  logic             take_ok, is_last;

  assign valid_o = (rem != '0) && word_avail;
  assign take_ok = take && valid_o;
  assign is_last = (rem == LEN_W'(1));
  assign pop_o   = take_ok && word_done(lane, is_last);
  assign byte_o  = lane_get(head, lane);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane <= '0;
      rem  <= '0;
    end else begin
      if (start) begin
        rem  <= len;
        lane <= '0;
      end else if (clr) begin
        rem  <= '0;
        lane <= '0;
      end else if (take_ok) begin
        rem  <= rem - LEN_W'(1);
        lane <= pop_o ? 2'd0 : lane + 2'd1;
      end
      if (flush) lane <= '0;
    end
  end

  AST_TX_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && is_last && !start |=> !valid_o); // R5
endmodule

// File: rtl/wfp_rx_pack.sv
module wfp_rx_pack
  import i2c_wfp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic             clr,
  input  logic [LEN_W-1:0] len,
  input  logic             space,
  input  logic [7:0]       byte_i,
  input  logic             push_i,
  output logic             ready_o,
  output logic [31:0]      word_o,
  output logic             wpush_o
);
  logic [1:0]       lane;
  logic [LEN_W-1:0] rem;
  logic [31:0]      acc;
  logic             push_ok, is_last;

  assign ready_o = (rem != '0) && space;
  assign push_ok = push_i && ready_o;
  assign is_last = (rem == LEN_W'(1));
  assign word_o  = lane_put(acc, lane, byte_i);
  assign wpush_o = push_ok && word_done(lane, is_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane <= '0;
      rem  <= '0;
      acc  <= '0;
    end else begin
      if (start) begin
        rem  <= len;
        lane <= '0;
        acc  <= '0;
      end else if (clr) begin
        rem  <= '0;
        lane <= '0;
        acc  <= '0;
      end else if (push_ok) begin
        rem  <= rem - LEN_W'(1);
        lane <= wpush_o ? 2'd0 : lane + 2'd1;
        acc  <= wpush_o ? 32'd0 : word_o;
      end
      if (flush) begin
        lane <= '0;
        acc  <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_word_fifo_pair.sv
module i2c_word_fifo_pair
  import i2c_wfp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             xfer_start,
  input  logic             xfer_rd,
  input  logic [LEN_W-1:0] xfer_len,
  output logic [7:0]       eng_tx_byte,
  output logic             eng_tx_valid,
  input  logic             eng_tx_take,
  input  logic [7:0]       eng_rx_byte,
  input  logic             eng_rx_push,
  output logic             eng_rx_ready,
  output logic             tx_req,
  output logic             rx_req
);
  localparam int CW = $clog2(DEPTH + 1);

  reg_sel_e sel;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic fl_tx, fl_rx, ovf, udf, tx_met_q, rx_met_q;
  logic ctrl_wr, txd_wr, rxd_rd;

  logic [31:0]   tx_head, rx_head, rx_word;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_push_rej, tx_pop_rej, rx_push_rej, rx_pop_rej;
  logic tx_pop, rx_wpush;
  logic [STAT_W-1:0] tx_free_s, rx_cnt_s, tx_lvl, rx_lvl;
  logic tx_met, rx_met;

  assign sel     = reg_sel_e'(reg_addr);
  assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
  assign txd_wr  = reg_wr && (sel == SEL_TXD);
  assign rxd_rd  = reg_rd && (sel == SEL_RXD);

  wfp_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(fl_tx),
    .push(txd_wr), .push_data(reg_wdata), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .push_rej(tx_push_rej), .pop_rej(tx_pop_rej)
  );

  wfp_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(fl_rx),
    .push(rx_wpush), .push_data(rx_word), .pop(rxd_rd),
    .head(rx_head), .count(rx_cnt), .push_rej(rx_push_rej), .pop_rej(rx_pop_rej)
  );

  wfp_tx_unpack #(.LEN_W(LEN_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(fl_tx),
    .start(xfer_start && !xfer_rd), .clr(xfer_start), .len(xfer_len),
    .word_avail(tx_cnt != '0), .head(tx_head), .take(eng_tx_take),
    .byte_o(eng_tx_byte), .valid_o(eng_tx_valid), .pop_o(tx_pop)
  );

  wfp_rx_pack #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(fl_rx),
    .start(xfer_start && xfer_rd), .clr(xfer_start), .len(xfer_len),
    .space(rx_cnt != CW'(DEPTH)), .byte_i(eng_rx_byte), .push_i(eng_rx_push),
    .ready_o(eng_rx_ready), .word_o(rx_word), .wpush_o(rx_wpush)
  );

  assign tx_free_s = STAT_W'(DEPTH) - STAT_W'(tx_cnt);
  assign rx_cnt_s  = STAT_W'(rx_cnt);
  assign tx_lvl    = trig_level(tx_trig);
  assign rx_lvl    = trig_level(rx_trig);
  assign tx_met    = (tx_free_s >= tx_lvl);
  assign rx_met    = (rx_cnt_s >= rx_lvl);
  assign tx_req    = tx_met && !tx_met_q;
  assign rx_req    = rx_met && !rx_met_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_trig  <= '0;
      rx_trig  <= '0;
      fl_tx    <= 1'b0;
      fl_rx    <= 1'b0;
      ovf      <= 1'b0;
      udf      <= 1'b0;
      tx_met_q <= 1'b0;
      rx_met_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        tx_trig <= reg_wdata[7:5];
        rx_trig <= reg_wdata[4:2];
      end
      // pending bit is set by the write and retired on the following edge
      fl_tx <= ctrl_wr && reg_wdata[1];
      fl_rx <= ctrl_wr && reg_wdata[0];
      if (fl_tx)            ovf <= 1'b0;
      else if (tx_push_rej) ovf <= 1'b1;
      if (fl_rx)            udf <= 1'b0;
      else if (rx_pop_rej)  udf <= 1'b1;
      tx_met_q <= tx_met;
      rx_met_q <= rx_met;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: reg_rdata = {24'd0, tx_trig, rx_trig, fl_tx, fl_rx};
      SEL_STAT: reg_rdata = {22'd0, udf, ovf, tx_free_s, rx_cnt_s};
      SEL_RXD:  reg_rdata = (rx_cnt == '0) ? 32'd0 : rx_head;
      default:  reg_rdata = 32'd0;
    endcase
  end

  AST_FLUSH_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_tx |=> tx_cnt == '0); // R8
  AST_FLUSH_RX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rx |=> rx_cnt == '0); // R8
  AST_TX_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pop_rej); // R5
  AST_RX_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_push_rej); // R6
  AST_RXREQ_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt_s >= rx_lvl) && !$past(rx_cnt_s >= rx_lvl) |-> rx_req); // R10
  AST_TXREQ_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free_s >= tx_lvl) && !$past(tx_free_s >= tx_lvl) |-> tx_req); // R9
endmodule

// File: tb/i2c_word_fifo_pair_test.sv
`timescale 1ns/1ps
module i2c_word_fifo_pair_test;
  localparam int DEPTH = 8;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic xfer_start = 1'b0, xfer_rd = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic [7:0] eng_tx_byte, eng_rx_byte = '0;
  logic eng_tx_valid, eng_tx_take = 1'b0, eng_rx_push = 1'b0, eng_rx_ready;
  logic tx_req, rx_req;

  i2c_word_fifo_pair #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uut (.*);

  int n_chk = 0, n_fail = 0, txp = 0, rxp = 0;
  logic [31:0] words [8];
  logic [31:0] rd, dummy;

  always @(posedge clk) begin
    if (tx_req) txp++;
    if (rx_req) rxp++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_of(input int free, input int cnt, input bit ov, input bit un);
    return {22'd0, un, ov, free[3:0], cnt[3:0]};
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic start_xfer(input bit rdir, input int len);
    xfer_start = 1'b1; xfer_rd = rdir; xfer_len = LEN_W'(len);
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic take(output logic [7:0] b);
    while (!eng_tx_valid) @(negedge clk);
    b = eng_tx_byte;
    eng_tx_take = 1'b1;
    @(negedge clk);
    eng_tx_take = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    while (!eng_rx_ready) @(negedge clk);
    eng_rx_byte = b; eng_rx_push = 1'b1;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] b;
    int len, nw;
    dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(2'd1, rd); check("R1 status", rd, 32'h080);
    bus_rd(2'd0, rd); check("R1 ctrl", rd, 32'h0);
    check("R1 tx_valid", {31'd0, eng_tx_valid}, 32'd0);
    check("R1 rx_ready", {31'd0, eng_rx_ready}, 32'd0);

    // R2 push words
    for (int i = 0; i < 3; i++) begin words[i] = $urandom; bus_wr(2'd2, words[i]); end
    bus_rd(2'd1, rd); check("R2 free after 3", rd, stat_of(5, 0, 0, 0));
    for (int i = 3; i < 8; i++) begin words[i] = $urandom; bus_wr(2'd2, words[i]); end
    bus_rd(2'd1, rd); check("R2 free at full", rd, stat_of(0, 0, 0, 0));
    // R3 overflow
    bus_wr(2'd2, 32'hDEADBEEF);
    bus_rd(2'd1, rd); check("R3 overflow flag", rd, stat_of(0, 0, 1, 0));
    // R4 byte order, contents kept
    start_xfer(1'b0, 32);
    for (int i = 0; i < 32; i++) begin
      take(b); check("R4 R3 tx byte", {24'd0, b}, {24'd0, byte_of(words[i/4], i%4)});
    end
    bus_rd(2'd1, rd); check("R3 sticky after drain", rd, stat_of(8, 0, 1, 0));

    // R8 TX flush self-clear
    bus_wr(2'd0, 32'h2);
    bus_rd(2'd0, rd); check("R8 tx flush pending", rd, 32'h2);
    bus_rd(2'd0, rd); check("R8 tx flush cleared", rd, 32'h0);
    bus_rd(2'd1, rd); check("R8 ovf cleared", rd, stat_of(8, 0, 0, 0));

    // R5 directed partial word, following word stays queued
    bus_wr(2'd2, 32'h44332211);
    bus_wr(2'd2, 32'hAABBCC55);
    bus_wr(2'd2, 32'h99887766);
    start_xfer(1'b0, 5);
    for (int i = 0; i < 5; i++) begin
      take(b); check("R5 partial bytes", {24'd0, b}, {24'd0, (i < 4) ? byte_of(32'h44332211, i) : 8'h55});
    end
    check("R5 valid low", {31'd0, eng_tx_valid}, 32'd0);
    bus_rd(2'd1, rd); check("R5 third word kept", rd, stat_of(7, 0, 0, 0));
    bus_wr(2'd0, 32'h2); @(negedge clk);

    // R4 R5 random write transfers
    for (int it = 0; it < 20; it++) begin
      len = 1 + int'($urandom % 20);
      nw = (len + 3) / 4;
      for (int i = 0; i < nw; i++) begin words[i] = $urandom; bus_wr(2'd2, words[i]); end
      start_xfer(1'b0, len);
      for (int i = 0; i < len; i++) begin
        take(b); check("R4 random tx byte", {24'd0, b}, {24'd0, byte_of(words[i/4], i%4)});
      end
      check("R5 random valid low", {31'd0, eng_tx_valid}, 32'd0);
      bus_rd(2'd1, rd); check("R5 random all popped", rd, stat_of(8, 0, 0, 0));
    end

    // R6 random read transfers
    for (int it = 0; it < 20; it++) begin
      len = 1 + int'($urandom % 20);
      nw = (len + 3) / 4;
      start_xfer(1'b1, len);
      for (int i = 0; i < nw; i++) words[i] = '0;
      for (int i = 0; i < len; i++) begin
        b = 8'($urandom);
        words[i/4][8*(i%4) +: 8] = b;
        put(b);
      end
      bus_rd(2'd1, rd); check("R6 rx count", rd, stat_of(8, nw, 0, 0));
      for (int i = 0; i < nw; i++) begin
        logic [31:0] m;
        int vl;
        vl = (len - 4*i >= 4) ? 4 : len - 4*i;
        m = (vl == 4) ? 32'hFFFFFFFF : ((32'd1 << (8*vl)) - 32'd1);
        bus_rd(2'd3, rd); check("R6 rx word lanes", rd & m, words[i] & m);
      end
    end

    // R7 underflow
    bus_rd(2'd3, rd);
    bus_rd(2'd1, rd); check("R7 underflow flag", rd, stat_of(8, 0, 0, 1));

    // R8 RX flush leaves TX alone
    bus_wr(2'd2, 32'h1); bus_wr(2'd2, 32'h2);
    start_xfer(1'b1, 8);
    for (int i = 0; i < 8; i++) put(8'(i));
    bus_rd(2'd1, rd); check("R8 before rx flush", rd, stat_of(6, 2, 0, 1));
    bus_wr(2'd0, 32'h1);
    bus_rd(2'd0, rd); check("R8 rx flush pending", rd, 32'h1);
    bus_rd(2'd0, rd); check("R8 rx flush cleared", rd, 32'h0);
    bus_rd(2'd1, rd); check("R8 rx flushed tx kept", rd, stat_of(6, 0, 0, 0));
    bus_wr(2'd0, 32'h2); @(negedge clk);
    bus_rd(2'd1, rd); check("R8 tx flushed", rd, stat_of(8, 0, 0, 0));

    // R9 TX request crossing, level 4 free
    bus_wr(2'd0, 32'h60);
    for (int i = 0; i < 8; i++) bus_wr(2'd2, 32'h0);
    @(negedge clk);
    txp = 0;
    start_xfer(1'b0, 32);
    for (int i = 0; i < 12; i++) take(b);
    @(negedge clk);
    check("R9 no pulse at 3 free", txp, 0);
    for (int i = 0; i < 4; i++) take(b);
    @(negedge clk);
    check("R9 pulse at 4 free", txp, 1);
    for (int i = 0; i < 16; i++) take(b);
    @(negedge clk);
    check("R9 single pulse", txp, 1);

    // R10 RX request crossing, level 3 words
    bus_wr(2'd0, 32'h08);
    @(negedge clk);
    rxp = 0;
    start_xfer(1'b1, 12);
    for (int i = 0; i < 8; i++) put(8'(i));
    @(negedge clk);
    check("R10 no pulse at 2 words", rxp, 0);
    for (int i = 0; i < 4; i++) put(8'(i));
    @(negedge clk);
    check("R10 pulse at 3 words", rxp, 1);
    for (int i = 0; i < 3; i++) bus_rd(2'd3, rd);
    @(negedge clk);
    check("R10 single pulse", rxp, 1);

    report();
  end
endmodule